// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is an 8-bit watchdog up-counter. Its count clock is a selectable fraction of the peripheral clock. Software controls it through two byte-wide registers, a count register and a control/status register, on a 16-bit register bus. A write to either register takes effect only when it is a 16-bit word access whose upper byte holds that register's own key. Any other write is dropped without notice, so a runaway program is unlikely to disturb the timer by accident.

While the timer is enabled, a 12-bit prescaler runs and produces count ticks at one of eight rates. Each tick advances the counter. When the counter wraps from 0xFF to 0x00, the block drives a single-cycle overflow pulse and sets a sticky overflow flag in the control/status register. Software keeps the timer from overflowing by reloading the count register in time. The overflow pulse is meant to drive a reset or interrupt source outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: Register address 0 selects the count register. A write there that is a word access with upper data byte 0x5A loads the lower data byte into the counter.
- R2: Register address 1 selects the control/status register. A word write with upper byte 0xA5 updates it. Bit 7 is the timer enable, bit 5 is the overflow flag and bits 2:0 are the clock select. All other bits read as 0.
- R3: The access size code is 00 for byte, 01 for word and 10 for 32-bit. Writes with any size code other than word change neither register.
- R4: A word write whose upper byte is not the key of the addressed register changes neither register. This includes the other register's key.
- R5: Clock select codes 0 to 7 divide the peripheral clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. After the timer is enabled from the stopped state, the counter advances by one at the end of every N-th clock, where N is the selected divisor.
- R6: The clock select resets to 000. A control write loads the clock select only when the timer is currently disabled. While the timer runs, the select bits of a control write are ignored.
- R7: The prescaler is cleared while the timer is disabled, so every enable starts a full divisor period. The counter holds its value while the timer is disabled.
- R8: When a tick arrives with the counter at 0xFF, the counter becomes 0x00 and the overflow flag is set. The overflow output is high for exactly that one cycle.
- R9: A control write with bit 5 at 0 clears the overflow flag. A write with bit 5 at 1 does not set it. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R10: A read returns the addressed register in the lower byte and zero in the upper byte, whatever the access size. After reset both registers read 0.
- R11: If a valid counter write coincides with a count tick, the written value wins and no wrap or overflow pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = count register, 1 = control/status register |
| bus_size | input | 2 | Access size code: 00 byte, 01 word, 10 32-bit |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 16 | Read data for the addressed register |
| ovf_pulse | output | 1 | One-cycle pulse in the cycle the counter wraps |

## Verification
The bench provokes two kinds of collision by running at divide-by-1 from a counter value of 0xFE. It then issues a register write in the exact clock where the counter sits at 0xFF and a tick is due.

In the first case, a control write clears the overflow flag while the wrap sets it. The overflow pulse must be seen in that cycle, and the flag must read back as set afterwards.

In the second case, a counter write lands on the wrap cycle. The overflow pulse must stay low, the written value must read back, and the flag must remain clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_WORD = 2'b01,
    ACC_LONG = 2'b10
  } acc_size_e;

  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam logic [7:0] KEY_CTRL  = 8'hA5;

  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned FLAG_BIT = 5;
  localparam int unsigned SEL_W    = 3;

  // log2 of the divisor for each clock-select code
  function automatic logic [3:0] sel_shift(input logic [SEL_W-1:0] sel);
    logic [3:0] s;
    case (sel)
      3'd0:    s = 4'd0;
      3'd1:    s = 4'd2;
      3'd2:    s = 4'd4;
      3'd3:    s = 4'd5;
      3'd4:    s = 4'd6;
      3'd5:    s = 4'd8;
      3'd6:    s = 4'd10;
      default: s = 4'd12;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdt_key_filter.sv
module wdt_key_filter
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              cnt_we,
  output logic              ctl_we,
  output logic [7:0]        wbyte
);

  localparam int unsigned KEY_LSB = DATA_W - 8;

  logic       word_wr;
  logic [7:0] key;

  always_comb begin
    key     = bus_wdata[KEY_LSB +: 8];
    wbyte   = bus_wdata[7:0];
    word_wr = bus_sel && bus_wr && (acc_size_e'(bus_size) == ACC_WORD);
    cnt_we  = word_wr && !bus_addr && (key == KEY_COUNT);
    ctl_we  = word_wr &&  bus_addr && (key == KEY_CTRL);
  end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask  = (PRE_W'(1) << sel_shift(sel)) - PRE_W'(1);
    tick  = run && ((pre_q & mask) == mask);
    pre_d = run ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R7: a stopped timer leaves the prescaler at zero
  a_r7_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

  // R5: at divide-by-1 every running cycle ticks
  a_r5_div1_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == '0) |-> tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = tick && !load && (cnt_q == '1);
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R1 / R11: a load lands exactly, even against a tick
  a_r1_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R8: a wrap leaves the counter at zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R7: without tick or load the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_pulse
);

  localparam int unsigned CNT_W = 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  logic             cnt_we, ctl_we;
  logic [7:0]       wbyte;
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt;

  logic             en_q, en_d;
  logic             flag_q, flag_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [7:0]       ctrl_view;

  wdt_key_filter #(.DATA_W(DATA_W)) u_filter (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .cnt_we   (cnt_we),
    .ctl_we   (ctl_we),
    .wbyte    (wbyte)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_in_n),
    .run  (en_q),
    .sel  (sel_q),
    .tick (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .tick    (tick),
    .load    (cnt_we),
    .load_val(wbyte),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  // control/status next state
  always_comb begin
    en_d   = ctl_we ? wbyte[EN_BIT] : en_q;
    sel_d  = (ctl_we && !en_q) ? wbyte[SEL_W-1:0] : sel_q;
    flag_d = flag_q;
    if (ctl_we && !wbyte[FLAG_BIT]) flag_d = 1'b0;
    if (wrap)                       flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    ctrl_view                  = '0;
    ctrl_view[EN_BIT]          = en_q;
    ctrl_view[FLAG_BIT]        = flag_q;
    ctrl_view[SEL_W-1:0]       = sel_q;
    bus_rdata                  = '0;
    bus_rdata[7:0]             = bus_addr ? ctrl_view : cnt;
  end

  assign ovf_pulse = wrap;

  // R6: clock select frozen while running
  a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rst_in_n)
    en_q |=> $stable(sel_q));

  // R8: a wrap always leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_in_n)
    ovf_pulse |=> flag_q);

  // R8: the overflow output never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_in_n)
    ovf_pulse |=> !ovf_pulse);

  // R3: a non-word write leaves enable and select untouched
  a_r3_size_filter: assert property (@(posedge clk) disable iff (!rst_in_n)
    (bus_sel && bus_wr && bus_size != 2'b01) |=> ($stable(en_q) && $stable(sel_q)));

  // R9: flag only falls after a control write
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_in_n)
    (flag_q && !ctl_we) |=> flag_q);

  // R10: upper read byte is always zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_in_n)
    bus_rdata[DATA_W-1:8] == '0);

endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_addr;
  logic [1:0]  bus_size;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ovf_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  keyed_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_pulse(ovf_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {addr, size, wdata, expected count, expected control}
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 2'b01, 16'h5A33, 8'h33, 8'h00},  // R1 valid counter write
    {1'b0, 2'b00, 16'h5A44, 8'h33, 8'h00},  // R3 byte ignored
    {1'b0, 2'b10, 16'h5A44, 8'h33, 8'h00},  // R3 long ignored
    {1'b0, 2'b01, 16'h5B44, 8'h33, 8'h00},  // R4 bad key
    {1'b0, 2'b01, 16'hA544, 8'h33, 8'h00},  // R4 control key on counter
    {1'b1, 2'b01, 16'hA503, 8'h33, 8'h03},  // R2 valid control write
    {1'b1, 2'b00, 16'hA505, 8'h33, 8'h03},  // R3 byte ignored
    {1'b1, 2'b10, 16'hA506, 8'h33, 8'h03},  // R3 long ignored
    {1'b1, 2'b01, 16'h5A06, 8'h33, 8'h03},  // R4 counter key on control
    {1'b1, 2'b01, 16'hA55F, 8'h33, 8'h07},  // R2/R9 spare bits dropped, flag not set
    {1'b0, 2'b01, 16'h5AFF, 8'hFF, 8'h07},  // R1
    {1'b1, 2'b01, 16'hA500, 8'hFF, 8'h00}   // R6 select loads while stopped
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [1:0] size, input logic [15:0] data);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_size = size; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic addr, input logic [1:0] size, output logic [15:0] data);
    bus_addr = addr; bus_size = size;
    #1 data = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int div;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
    bus_size = 2'b01; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10 reset state
    rd(1'b0, 2'b01, r); check("R10 reset count", r, 16'h0000);
    rd(1'b1, 2'b01, r); check("R10 reset control", r, 16'h0000);
    check("R8 reset pulse", {15'd0, ovf_pulse}, 16'h0000);

    // table walk, timer stopped
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][34], VEC[i][33:32], VEC[i][31:16]);
      rd(1'b0, VEC[i][33:32], r);
      check($sformatf("R1-R4 vec%0d count", i), r, {8'h00, VEC[i][15:8]});
      rd(1'b1, VEC[i][33:32], r);
      check($sformatf("R2-R4 vec%0d control", i), r, {8'h00, VEC[i][7:0]});
    end

    // R5 / R7 each divisor: count holds div-1 cycles, steps on the div-th
    for (int s = 0; s < 8; s++) begin
      case (s)
        0: div = 1;    1: div = 4;    2: div = 16;   3: div = 32;
        4: div = 64;   5: div = 256;  6: div = 1024; default: div = 4096;
      endcase
      wr(1'b1, 2'b01, 16'hA500);
      wr(1'b0, 2'b01, 16'h5A10);
      wr(1'b1, 2'b01, 16'hA580 | 16'(s));
      if (div > 1) begin
        idle(div - 1);
        rd(1'b0, 2'b01, r); check($sformatf("R5 sel%0d before", s), r, 16'h0010);
        idle(1);
      end else idle(1);
      rd(1'b0, 2'b01, r); check($sformatf("R5 sel%0d step", s), r, 16'h0011);
      idle(div);
      rd(1'b0, 2'b01, r); check($sformatf("R5 sel%0d second", s), r, 16'h0012);
    end

    // R6 select ignored while running (currently sel 7, enabled)
    wr(1'b1, 2'b01, 16'hA582);
    rd(1'b1, 2'b01, r); check("R6 select frozen", r, 16'h0087);

    // R7 count holds while stopped
    wr(1'b1, 2'b01, 16'hA500);
    rd(1'b0, 2'b01, r);
    idle(20);
    begin
      logic [15:0] r2;
      rd(1'b0, 2'b01, r2); check("R7 hold when stopped", r2, r);
    end

    // R8 wrap at divide-by-1
    wr(1'b1, 2'b01, 16'hA500);
    wr(1'b0, 2'b01, 16'h5AFD);
    wr(1'b1, 2'b01, 16'hA580);
    idle(1);
    rd(1'b0, 2'b01, r); check("R8 count FE", r, 16'h00FE);
    check("R8 no pulse at FE", {15'd0, ovf_pulse}, 16'h0000);
    idle(1);
    rd(1'b0, 2'b01, r); check("R8 count FF", r, 16'h00FF);
    check("R8 pulse at wrap", {15'd0, ovf_pulse}, 16'h0001);
    idle(1);
    rd(1'b0, 2'b01, r); check("R8 count wrapped", r, 16'h0000);
    check("R8 pulse one cycle", {15'd0, ovf_pulse}, 16'h0000);
    rd(1'b1, 2'b01, r); check("R8 flag set", r, 16'h00A0);

    // R9 write 0 to flag clears
    wr(1'b1, 2'b01, 16'hA500);
    rd(1'b1, 2'b01, r); check("R9 flag cleared", r, 16'h0000);

    // R9 clear and wrap in the same cycle: set wins
    wr(1'b0, 2'b01, 16'h5AFE);
    wr(1'b1, 2'b01, 16'hA580);
    idle(1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_size = 2'b01; bus_wdata = 16'hA580;
    #1 check("R8 pulse during clear", {15'd0, ovf_pulse}, 16'h0001);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(1'b1, 2'b01, r); check("R9 set beats clear", r, 16'h00A0);

    // R11 counter write on the wrap cycle wins
    wr(1'b1, 2'b01, 16'hA500);
    wr(1'b0, 2'b01, 16'h5AFE);
    wr(1'b1, 2'b01, 16'hA580);
    idle(1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_size = 2'b01; bus_wdata = 16'h5A40;
    #1 check("R11 no pulse on load", {15'd0, ovf_pulse}, 16'h0000);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(1'b0, 2'b01, r); check("R11 loaded value", r, 16'h0040);
    rd(1'b1, 2'b01, r); check("R11 flag stays clear", r, 16'h0080);

    // R10 read with 32-bit size
    rd(1'b1, 2'b10, r); check("R10 long read", r, 16'h0080);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule